// File: doc/BRIEF.md
# E1 Frame Alignment Receiver

This block watches a serial 2.048 Mbit/s PCM line, one bit per clock, and finds the 7-bit alignment word that appears in timeslot zero of every second frame. It searches bit by bit. When it sees a candidate, it places its frame timebase on that candidate. It then confirms the candidate in two further steps before it declares alignment. Once aligned, it tracks the word in each sync frame and drops alignment after a fixed number of corrupted words in a row.

A 256-bit frame counter and a frame parity bit keep running at all times. All timing outputs are decoded from them: a timeslot-zero marker, a sync/non-sync frame indicator, a low strobe in timeslot 1 of sync frames, and an 8 kHz half-frame clock. When alignment is lost these outputs keep their phase until a new candidate moves the timebase. The counter and the parity bit are also exported so that downstream logic can pick out bits of timeslot zero.

The alignment controller has four states:
- `ST_HUNT`: bit-by-bit search.
- `ST_CHK_NS`: checks bit 2 of timeslot zero in the next frame.
- `ST_CHK_FAS`: checks the word again two frames after the first find.
- `ST_LOCK`: aligned.

Its transitions are:
- Hunt to check-ns on any pattern match, which also reloads the timebase.
- Check-ns to check-fas when that bit 2 is 1, and back to hunt when it is 0.
- Check-fas to lock on a match, and back to hunt on a mismatch.
- Lock to hunt on the third corrupted word in a row.
- Any state to hunt on the reset-alignment input.

Top module: `e1fa_receiver`

## Requirements
- R1: The alignment word is 0011011. It occupies bits 2 to 8 of timeslot zero, and bit 2 is received first. During a hunt, a match at any bit position moves the timebase so that the next bit is bit_pos 8 with frame_par 1.
- R2: Alignment is declared only after three steps in order: a find, then a 1 in bit 2 of timeslot zero of the next frame, then the word again two frames after the find. ooa_alarm falls as bit_pos becomes 8 in that second sync frame.
- R3: A 0 in the confirming bit 2, or a missing word at the second check, returns the block to hunting. No lock occurs at that frame.
- R4: While aligned, a sync frame with a corrupted word raises fas_err_alarm for one frame. The alarm is high from bit_pos 8 of that frame through bit_pos 7 of the next frame. It is never raised while the block is out of alignment.
- R5: Three corrupted sync words in a row cause loss of alignment. ooa_alarm rises at bit_pos 8 of the third such frame. A good word in between restarts the count.
- R6: A high rst_align at a clock edge puts the block out of alignment from the next cycle and restarts the hunt.
- R7: ooa_alarm is high exactly when the block is not aligned. in_sync is its complement.
- R8: ts0_mark is high for bit_pos 0 to 7 and low otherwise.
- R9: frame_ind is high from bit_pos 9 of a sync frame until bit_pos 8 of the following non-sync frame. It is low over the opposite span.
- R10: half_clk is low for bit_pos 7 to 134 and high for the rest of the frame.
- R11: ts1_strobe_n is low only at bit_pos 8 of sync frames (frame_par 1).
- R12: bit_pos counts 0 to 255 and wraps. frame_par is 1 during sync frames and toggles at each wrap. Both keep their phase through loss and reacquisition of alignment.
- R13: During reset, ooa_alarm is 1, fas_err_alarm is 0, bit_pos is 0, frame_par is 0 and ts0_mark is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial line data, sampled on the rising edge |
| rst_align | input | 1 | Forces loss of alignment and a new hunt |
| ts0_mark | output | 1 | High across timeslot zero |
| frame_ind | output | 1 | Frame-rate square wave, high for sync frames |
| ts1_strobe_n | output | 1 | Low for bit 1 of timeslot 1 in sync frames |
| half_clk | output | 1 | 8 kHz half-frame clock |
| fas_err_alarm | output | 1 | Corrupted-word alarm, one frame long |
| ooa_alarm | output | 1 | Out-of-alignment alarm |
| in_sync | output | 1 | Aligned flag |
| frame_par | output | 1 | 1 during sync frames |
| bit_pos | output | 8 | Bit position within the frame, 0 to 255 |

## Verification
The bench builds the block with its default parameters: a 256-bit frame, 8-bit timeslots, a loss limit of three and the standard word. These values reach every edge position in the requirements (7, 8, 9 and 134) and allow a full lock, three-strike loss and reacquisition cycle within about thirty frames. Payload bits are random, but constrained so that no copy of the word can appear outside timeslot zero. A random start offset therefore exercises the hunt without any risk of false lock. Directed frames then cover the confirming-bit failure, the second-check failure, the counter restart after a good word, and a reset-alignment pulse in mid-frame.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CHK_NS  = 2'd1,
        ST_CHK_FAS = 2'd2,
        ST_LOCK    = 2'd3
    } fa_state_e;
endpackage

// File: rtl/e1fa_timebase.sv
// Free-running frame counter with parity; load snaps to the bit after timeslot zero of a sync frame.
module e1fa_timebase #(
    parameter int FRAME_BITS = 256,
    parameter int TS_BITS    = 8,
    parameter int CW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    output logic [CW-1:0] cnt,
    output logic          par
);
    localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] LOAD_POS = CW'(TS_BITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            par <= 1'b0;
        end else if (load) begin
            cnt <= LOAD_POS;
            par <= 1'b1;
        end else if (cnt == LAST_POS) begin
            cnt <= '0;
            par <= ~par;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/e1fa_fas_detect.sv
// Sliding-window matcher: the current bit completes the window.
module e1fa_fas_detect #(
    parameter int               PAT_W   = 7,
    parameter logic [PAT_W-1:0] PATTERN = 7'b0011011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic match
);
    logic [PAT_W-2:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '1;
        else        hist <= {hist[PAT_W-3:0], din};
    end

    assign match = ({hist, din} == PATTERN);
endmodule

// File: rtl/e1fa_timing_gen.sv
// Decodes the timing outputs from the frame counter and parity.
module e1fa_timing_gen #(
    parameter int FRAME_BITS = 256,
    parameter int TS_BITS    = 8,
    parameter int CW         = $clog2(FRAME_BITS)
) (
    input  logic [CW-1:0] cnt,
    input  logic          par,
    output logic          ts0_mark,
    output logic          frame_ind,
    output logic          ts1_strobe_n,
    output logic          half_clk
);
    localparam int              HALF_POS = FRAME_BITS / 2;
    localparam logic [CW-1:0]   TS1_B1   = CW'(TS_BITS);
    localparam logic [CW-1:0]   LOW_FROM = CW'(TS_BITS - 1);
    localparam logic [CW-1:0]   LOW_TO   = CW'(HALF_POS + TS_BITS - 2);

    always_comb begin
        ts0_mark     = (cnt < TS1_B1);
        frame_ind    = (cnt > TS1_B1) ? par : ~par;
        ts1_strobe_n = ~(par && (cnt == TS1_B1));
        half_clk     = ~((cnt >= LOW_FROM) && (cnt <= LOW_TO));
    end
endmodule

// File: rtl/e1fa_align_fsm.sv
// Hunt / confirm / lock controller with consecutive-error loss rule.
module e1fa_align_fsm
    import e1fa_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int TS_BITS    = 8,
    parameter int LOSS_LIMIT = 3,
    parameter int CW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_align,
    input  logic          din,
    input  logic          match,
    input  logic [CW-1:0] cnt,
    input  logic          par,
    output logic          realign,
    output logic          locked,
    output logic          fas_err
);
    localparam int            BW       = $clog2(LOSS_LIMIT + 1);
    localparam logic [BW-1:0] LAST_HIT = BW'(LOSS_LIMIT - 1);
    localparam logic [CW-1:0] WORD_END = CW'(TS_BITS - 1);

    fa_state_e     state_q, state_d;
    logic [BW-1:0] bad_q;
    logic          at_fas, at_b2, last_strike;

    assign at_fas      = (cnt == WORD_END) && par;
    assign at_b2       = (cnt == CW'(1)) && !par;
    assign last_strike = (bad_q == LAST_HIT);

    always_comb begin
        state_d = state_q;
        realign = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (match) begin
                    state_d = ST_CHK_NS;
                    realign = 1'b1;
                end
            end
            ST_CHK_NS: begin
                if (at_b2) state_d = din ? ST_CHK_FAS : ST_HUNT;
            end
            ST_CHK_FAS: begin
                if (at_fas) state_d = match ? ST_LOCK : ST_HUNT;
            end
            ST_LOCK: begin
                if (at_fas && !match && last_strike) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
        if (rst_align) begin
            state_d = ST_HUNT;
            realign = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_q   <= '0;
            fas_err <= 1'b0;
        end else if (rst_align || state_q != ST_LOCK) begin
            bad_q   <= '0;
            fas_err <= 1'b0;
        end else begin
            if (at_fas) bad_q <= match ? '0 : bad_q + 1'b1;
            if (cnt == WORD_END) fas_err <= at_fas && !match && !last_strike;
        end
    end

    assign locked = (state_q == ST_LOCK);
endmodule

// File: rtl/e1fa_receiver.sv
module e1fa_receiver #(
    parameter int       FRAME_BITS  = 256,
    parameter int       TS_BITS     = 8,
    parameter int       LOSS_LIMIT  = 3,
    parameter int       PAT_W       = 7,
    parameter bit [6:0] FAS_PATTERN = 7'b0011011
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          din,
    input  logic                          rst_align,
    output logic                          ts0_mark,
    output logic                          frame_ind,
    output logic                          ts1_strobe_n,
    output logic                          half_clk,
    output logic                          fas_err_alarm,
    output logic                          ooa_alarm,
    output logic                          in_sync,
    output logic                          frame_par,
    output logic [$clog2(FRAME_BITS)-1:0] bit_pos
);
    localparam int CW = $clog2(FRAME_BITS);

    logic          match, realign, locked, par;
    logic [CW-1:0] cnt;

    e1fa_timebase #(.FRAME_BITS(FRAME_BITS), .TS_BITS(TS_BITS), .CW(CW)) u_tb (
        .clk(clk), .rst_n(rst_n), .load(realign), .cnt(cnt), .par(par)
    );

    e1fa_fas_detect #(.PAT_W(PAT_W), .PATTERN(PAT_W'(FAS_PATTERN))) u_det (
        .clk(clk), .rst_n(rst_n), .din(din), .match(match)
    );

    e1fa_align_fsm #(
        .FRAME_BITS(FRAME_BITS), .TS_BITS(TS_BITS), .LOSS_LIMIT(LOSS_LIMIT), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rst_align(rst_align), .din(din), .match(match),
        .cnt(cnt), .par(par), .realign(realign), .locked(locked), .fas_err(fas_err_alarm)
    );

    e1fa_timing_gen #(.FRAME_BITS(FRAME_BITS), .TS_BITS(TS_BITS), .CW(CW)) u_tim (
        .cnt(cnt), .par(par), .ts0_mark(ts0_mark), .frame_ind(frame_ind),
        .ts1_strobe_n(ts1_strobe_n), .half_clk(half_clk)
    );

    assign in_sync   = locked;
    assign ooa_alarm = ~locked;
    assign frame_par = par;
    assign bit_pos   = cnt;
endmodule

// File: rtl/e1fa_receiver_chk.sv
module e1fa_receiver_chk #(
    parameter int CW      = 8,
    parameter int TS_BITS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rst_align,
    input logic          ts0_mark,
    input logic          frame_ind,
    input logic          ts1_strobe_n,
    input logic          half_clk,
    input logic          fas_err_alarm,
    input logic          ooa_alarm,
    input logic          in_sync,
    input logic          frame_par,
    input logic [CW-1:0] bit_pos
);
    AST_RST_ALIGN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_align |=> ooa_alarm); // R6
    AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        fas_err_alarm |-> !ooa_alarm); // R4
    AST_LOCK_ENTRY_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ooa_alarm) |-> (bit_pos == CW'(TS_BITS)) && frame_par); // R2
    AST_TS0_RISE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ts0_mark) |-> bit_pos == '0); // R8
    AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !ts1_strobe_n) |=> ts1_strobe_n); // R11
    AST_HALF_FALL_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && $fell(half_clk)) |-> bit_pos == CW'(TS_BITS - 1)); // R10
    AST_IND_TOGGLE_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !$stable(frame_ind)) |-> bit_pos == CW'(TS_BITS + 1)); // R9
endmodule

bind e1fa_receiver e1fa_receiver_chk #(.CW(CW), .TS_BITS(TS_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_align(rst_align), .ts0_mark(ts0_mark),
    .frame_ind(frame_ind), .ts1_strobe_n(ts1_strobe_n), .half_clk(half_clk),
    .fas_err_alarm(fas_err_alarm), .ooa_alarm(ooa_alarm), .in_sync(in_sync),
    .frame_par(frame_par), .bit_pos(bit_pos)
);

// File: tb/e1fa_receiver_test.sv
module e1fa_receiver_test;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_BITS = 256;
    localparam int CW         = 8;

    typedef enum {K_NORMAL, K_BADFAS, K_NSLOW} kind_e;

    logic          clk = 1'b0;
    logic          rst_n, din, rst_align;
    logic          ts0_mark, frame_ind, ts1_strobe_n, half_clk;
    logic          fas_err_alarm, ooa_alarm, in_sync, frame_par;
    logic [CW-1:0] bit_pos;

    int n_chk = 0;
    int n_fail = 0;
    int fr = 1;
    bit chk_phase = 1'b0;
    bit s_err [FRAME_BITS];
    bit s_ooa [FRAME_BITS];

    e1fa_receiver uut (
        .clk(clk), .rst_n(rst_n), .din(din), .rst_align(rst_align),
        .ts0_mark(ts0_mark), .frame_ind(frame_ind), .ts1_strobe_n(ts1_strobe_n),
        .half_clk(half_clk), .fas_err_alarm(fas_err_alarm), .ooa_alarm(ooa_alarm),
        .in_sync(in_sync), .frame_par(frame_par), .bit_pos(bit_pos)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_tsz(int p);
        return p < 8;
    endfunction
    function automatic bit exp_ind(int p, bit sync);
        return (p >= 9) ? sync : !sync;
    endfunction
    function automatic bit exp_stb(int p, bit sync);
        return !(sync && p == 8);
    endfunction
    function automatic bit exp_hclk(int p);
        return !(p >= 7 && p <= 134);
    endfunction

    // Payload has a forced 1 in every other bit so no copy of the word can appear outside TS0.
    function automatic bit gen_bit(kind_e kind, bit sync, int p);
        bit [6:0] pat;
        if (p >= 8) return (p % 2 == 1) ? 1'b1 : 1'($urandom);
        if (sync) begin
            if (p == 0) return 1'($urandom);
            pat = (kind == K_BADFAS) ? 7'b0011111 : 7'b0011011;
            return pat[7 - p];
        end
        if (p == 0) return (kind == K_NSLOW) ? 1'b1 : 1'($urandom);
        if (p == 1) return (kind == K_NSLOW) ? 1'b0 : 1'b1;
        return (p % 2 == 1) ? 1'b1 : 1'($urandom);
    endfunction

    task automatic send_frame(input kind_e kind, input int start, input int rst_pos);
        bit sync;
        sync = (fr % 2 == 0);
        for (int p = start; p < FRAME_BITS; p++) begin
            @(negedge clk);
            s_err[p] = fas_err_alarm;
            s_ooa[p] = ooa_alarm;
            if (chk_phase) begin
                check(ts0_mark == exp_tsz(p), "R8 ts0_mark", ts0_mark, exp_tsz(p));
                check(frame_ind == exp_ind(p, sync), "R9 frame_ind", frame_ind, exp_ind(p, sync));
                check(half_clk == exp_hclk(p), "R10 half_clk", half_clk, exp_hclk(p));
                check(ts1_strobe_n == exp_stb(p, sync), "R11 ts1_strobe_n", ts1_strobe_n, exp_stb(p, sync));
                check(int'(bit_pos) == p, "R12 bit_pos", bit_pos, p);
                check(frame_par == sync, "R12 frame_par", frame_par, sync);
            end
            rst_align = (p == rst_pos);
            din = gen_bit(kind, sync, p);
        end
        fr++;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
        finish_run();
    end

    initial begin
        int off;
        void'($urandom(32'd5171));
        rst_n = 1'b0;
        din = 1'b1;
        rst_align = 1'b0;
        repeat (3) @(negedge clk);
        // R13 reset state
        check(ooa_alarm == 1'b1, "R13 ooa_alarm", ooa_alarm, 1);
        check(fas_err_alarm == 1'b0, "R13 fas_err_alarm", fas_err_alarm, 0);
        check(bit_pos == '0, "R13 bit_pos", bit_pos, 0);
        check(frame_par == 1'b0, "R13 frame_par", frame_par, 0);
        check(ts0_mark == 1'b1, "R13 ts0_mark", ts0_mark, 1);
        rst_n = 1'b1;

        off = int'($urandom_range(FRAME_BITS - 1, 0));
        send_frame(K_NORMAL, off, -1);                       // fr1, random start offset
        repeat (4) send_frame(K_NORMAL, 0, -1);              // fr2..5
        chk_phase = 1'b1;
        repeat (4) send_frame(K_NORMAL, 0, -1);              // fr6..9
        check(in_sync == 1'b1, "R1 acquired", in_sync, 1);
        check(ooa_alarm == 1'b0, "R7 aligned", ooa_alarm, 0);

        send_frame(K_BADFAS, 0, -1);                         // fr10
        check(s_err[7] == 1'b0, "R4 err before check", s_err[7], 0);
        check(s_err[8] == 1'b1, "R4 err rise", s_err[8], 1);
        check(s_err[255] == 1'b1, "R4 err held", s_err[255], 1);
        check(s_ooa[8] == 1'b0, "R5 one strike", s_ooa[8], 0);
        send_frame(K_NORMAL, 0, -1);                         // fr11
        check(s_err[7] == 1'b1, "R4 err last bit", s_err[7], 1);
        check(s_err[8] == 1'b0, "R4 err clear", s_err[8], 0);
        send_frame(K_NORMAL, 0, -1);                         // fr12 good word
        check(s_err[8] == 1'b0, "R4 no err on good", s_err[8], 0);
        send_frame(K_NORMAL, 0, -1);                         // fr13
        send_frame(K_BADFAS, 0, -1);                         // fr14
        check(s_err[8] == 1'b1, "R4 err second", s_err[8], 1);
        send_frame(K_NORMAL, 0, -1);                         // fr15
        send_frame(K_BADFAS, 0, -1);                         // fr16
        check(s_ooa[8] == 1'b0, "R5 count restarted", s_ooa[8], 0);
        check(s_err[8] == 1'b1, "R4 err third frame", s_err[8], 1);
        send_frame(K_NORMAL, 0, -1);                         // fr17
        send_frame(K_BADFAS, 0, -1);                         // fr18 third in a row
        check(s_ooa[7] == 1'b0, "R5 before loss", s_ooa[7], 0);
        check(s_ooa[8] == 1'b1, "R5 loss", s_ooa[8], 1);
        check(s_err[8] == 1'b0, "R4 no err at loss", s_err[8], 0);
        send_frame(K_NORMAL, 0, -1);                         // fr19
        check(s_ooa[100] == 1'b1, "R7 out of alignment", s_ooa[100], 1);
        check(in_sync == 1'b0, "R7 in_sync low", in_sync, 0);
        repeat (2) send_frame(K_NORMAL, 0, -1);              // fr20..21
        send_frame(K_NORMAL, 0, -1);                         // fr22
        check(s_ooa[7] == 1'b1, "R2 lock edge before", s_ooa[7], 1);
        check(s_ooa[8] == 1'b0, "R2 relock", s_ooa[8], 0);

        send_frame(K_NORMAL, 0, 100);                        // fr23 reset-alignment pulse
        check(s_ooa[100] == 1'b0, "R6 before pulse", s_ooa[100], 0);
        check(s_ooa[101] == 1'b1, "R6 after pulse", s_ooa[101], 1);
        send_frame(K_NORMAL, 0, -1);                         // fr24 find
        send_frame(K_NSLOW, 0, -1);                          // fr25 confirming bit 0
        send_frame(K_NORMAL, 0, -1);                         // fr26
        check(s_ooa[8] == 1'b1, "R3 bit2 failure", s_ooa[8], 1);
        send_frame(K_NORMAL, 0, -1);                         // fr27
        send_frame(K_BADFAS, 0, -1);                         // fr28 second check fails
        check(s_ooa[8] == 1'b1, "R3 second check failure", s_ooa[8], 1);
        check(s_err[8] == 1'b0, "R4 no err out of lock", s_err[8], 0);
        send_frame(K_NORMAL, 0, -1);                         // fr29
        send_frame(K_NORMAL, 0, -1);                         // fr30 find
        check(s_ooa[8] == 1'b1, "R3 hunt restarted", s_ooa[8], 1);
        send_frame(K_NORMAL, 0, -1);                         // fr31
        send_frame(K_NORMAL, 0, -1);                         // fr32
        check(s_ooa[8] == 1'b0, "R2 lock after retries", s_ooa[8], 0);
        repeat (2) send_frame(K_NORMAL, 0, -1);              // fr33..34
        check(in_sync == 1'b1, "R2 held", in_sync, 1);
        finish_run();
    end
endmodule